// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits on the host side of a serial NOR flash and turns block-level requests into complete SPI transactions. A client strobes one of four requests: identify the part, read one or more 256-byte pages, program one page, or erase one sector. The request carries an opcode, a block index and a page count. The sequencer then produces every transaction the request needs on a mode-3 SPI master. It drives the chip select, serial clock and MOSI, and it samples MISO.

Each read, program or erase starts with a status-poll transaction. The poll repeats filler bytes until the write-in-progress flag reads clear. A program or erase then gets its own write-enable transaction before the real command. Identification reads three ID bytes and sets the sector geometry from the capacity byte: a shift of 16 for the smaller device and 18 for the larger. Read data leaves on a byte stream with a valid pulse. Program data is pulled byte by byte from the client with a take pulse. Completion is a one-cycle done pulse, and an error flag accompanies it when identification fails.

Controller states: `ST_IDLE`, `ST_POLL_CMD` (status opcode), `ST_POLL_WAIT` (filler bytes until the busy flag clears), `ST_POLL_GAP` (select released), `ST_WEN` (write-enable opcode), `ST_WEN_GAP` (select released), `ST_OPCODE`, `ST_ADDR` (three address bytes), `ST_RD_DATA`, `ST_WR_DATA`, `ST_ID_BYTES` and `ST_FINISH`. The transitions are:
- `ST_IDLE` goes to `ST_OPCODE` on an identify strobe, and to `ST_POLL_CMD` on any other strobe.
- `ST_POLL_CMD` goes to `ST_POLL_WAIT`. `ST_POLL_WAIT` stays while bit 0 of the received byte is 1, and goes to `ST_POLL_GAP` once it is 0.
- `ST_POLL_GAP` goes to `ST_OPCODE` for a read, and to `ST_WEN` for a program or erase. `ST_WEN` goes to `ST_WEN_GAP`, which goes to `ST_OPCODE`.
- `ST_OPCODE` goes to `ST_ID_BYTES` for identify, and to `ST_ADDR` otherwise.
- After three bytes, `ST_ADDR` goes to `ST_RD_DATA`, to `ST_WR_DATA`, or to `ST_FINISH`. It goes to `ST_FINISH` for an erase, and for a read of zero pages.
- `ST_RD_DATA`, `ST_WR_DATA` and `ST_ID_BYTES` go to `ST_FINISH` after their last byte. `ST_FINISH` returns to `ST_IDLE`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, `spi_cs_n` and `spi_sck` are high and `busy` and `done` are low.
- R2: A strobe on `req_valid` is taken only while `busy` is low. `busy` is high from the cycle after the strobe until `done`. Strobes while busy are ignored: they produce no extra transaction and no extra `done`.
- R3: Identify (`req_op` = 0) is a single transaction with opcode 0x9F followed by three filler bytes, with no status poll.
- R4: Identification succeeds only if the first two ID bytes both equal 0x20. Capacity 0x17 then sets `geo_shift` = 16 and capacity 0x18 sets `geo_shift` = 18; either raises `geo_valid`. Any other ID raises `err` with `done` and clears `geo_valid`.
- R5: Read (`req_op` = 1), program (2) and erase (3) first run a transaction of opcode 0x05 followed by filler bytes. Chip select is released right after the first byte whose bit 0 is 0.
- R6: Program and erase are preceded by a separate one-byte transaction with opcode 0x06, issued after the poll. Chip select goes high between it and the command.
- R7: Read, program and erase send a 24-bit address right after the opcode, most significant byte first. For read and program the address is the page index shifted left by 8.
- R8: Read is one transaction of opcode 0x03 that clocks `req_count`×256 data bytes after the address. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in order. A count of 0 sends no data bytes.
- R9: Program is one transaction of opcode 0x02 followed by exactly 256 data bytes. Each byte is the value on `wr_data` in a cycle where `wr_take` pulses, and there is one pulse per byte.
- R10: Erase is one transaction of opcode 0xD8 with no data bytes. Its address is the sector index shifted left by the current `geo_shift`, which is 16 after reset.
- R11: The link is SPI mode 3 with 8-bit frames, MSB first. `spi_sck` idles high. MOSI changes only on falling edges, and each clock level lasts at least `CLK_DIV` cycles. The filler byte sent while receiving is 0xA5.
- R12: `done` is a one-cycle pulse issued with chip select high. `err` is asserted only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request start strobe |
| req_op | input | 2 | 0 identify, 1 read, 2 program, 3 erase |
| req_index | input | IDX_W | Page index (read/program) or sector index (erase) |
| req_count | input | CNT_W | Number of pages for a read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Identification failure, valid with done |
| geo_valid | output | 1 | A supported device was identified |
| geo_shift | output | 5 | Sector size as a power of two |
| wr_data | input | 8 | Program data byte |
| wr_take | output | 1 | Program byte on wr_data is consumed this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each serial byte takes 16×`CLK_DIV` cycles plus a one-cycle start. Because of this, the bench does not predict the exact cycle of each edge. It waits for `done` at falling clock edges and then judges the whole transaction log recorded by its flash model. Two results have a fixed latency and are checked at that cycle: `busy` is due at the first falling edge after the strobe, and `done` must be gone one cycle after it rises. `rd_valid` arrives one cycle after each received byte completes. `wr_data` is advanced only one full cycle after a `wr_take` pulse, so the byte latched in the take cycle is the one expected.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_IDENT = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } req_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_CMD,
        ST_POLL_WAIT,
        ST_POLL_GAP,
        ST_WEN,
        ST_WEN_GAP,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_ID_BYTES,
        ST_FINISH
    } seq_state_e;

    // serial command codes
    localparam logic [7:0] CMD_WR_EN      = 8'h06;
    localparam logic [7:0] CMD_IDENT      = 8'h9F;
    localparam logic [7:0] CMD_STATUS     = 8'h05;
    localparam logic [7:0] CMD_RD         = 8'h03;
    localparam logic [7:0] CMD_PAGE_WR    = 8'h02;
    localparam logic [7:0] CMD_SECT_ERASE = 8'hD8;
    localparam logic [7:0] FILLER_BYTE    = 8'hA5;

    // identification codes
    localparam logic [7:0] VENDOR_CODE = 8'h20;
    localparam logic [7:0] TYPE_CODE   = 8'h20;
    localparam logic [7:0] CAP_SMALL   = 8'h17;
    localparam logic [7:0] CAP_LARGE   = 8'h18;

    localparam int PAGE_SHIFT  = 8;
    localparam int SHIFT_SMALL = 16;
    localparam int SHIFT_LARGE = 18;
    localparam int ADDR_W      = 24;
    localparam int SHIFT_W     = 5;
    localparam int ADDR_BYTES  = ADDR_W / 8;

endpackage

// File: rtl/nor_spi_byte.sv
// One 8-bit mode-3 frame per start pulse, MSB first.
module nor_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       frame_done
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic          active;
    logic          high_ph;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= 1'b0;
            high_ph    <= 1'b0;
            cnt        <= '0;
            bitn       <= '0;
            sh         <= '0;
            sck        <= 1'b1;
            mosi       <= 1'b1;
            rx_byte    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    high_ph <= 1'b0;
                    cnt     <= '0;
                    bitn    <= '0;
                    sh      <= tx_byte;
                    sck     <= 1'b0;
                    mosi    <= tx_byte[7];
                end
            end else if (cnt != CNT_LAST) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (!high_ph) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                    high_ph <= 1'b1;
                end else if (bitn == 3'd7) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                end else begin
                    sck     <= 1'b0;
                    sh      <= {sh[6:0], 1'b0};
                    mosi    <= sh[6];
                    bitn    <= bitn + 3'd1;
                    high_ph <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/nor_id_decode.sv
// Maps the three identification bytes to a sector geometry.
module nor_id_decode
    import nor_seq_pkg::*;
(
    input  logic [23:0]        id_bytes,
    output logic               known,
    output logic [SHIFT_W-1:0] shift
);
    always_comb begin
        known = 1'b0;
        shift = SHIFT_W'(SHIFT_SMALL);
        if (id_bytes[23:16] == VENDOR_CODE && id_bytes[15:8] == TYPE_CODE) begin
            if (id_bytes[7:0] == CAP_SMALL) begin
                known = 1'b1;
                shift = SHIFT_W'(SHIFT_SMALL);
            end else if (id_bytes[7:0] == CAP_LARGE) begin
                known = 1'b1;
                shift = SHIFT_W'(SHIFT_LARGE);
            end
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [CNT_W-1:0]   req_count,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               geo_valid,
    output logic [SHIFT_W-1:0] geo_shift,
    input  logic [7:0]         wr_data,
    output logic               wr_take,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    output logic               spi_cs_n,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int DW = CNT_W + PAGE_SHIFT;
    localparam logic [DW-1:0] PAGE_LAST = DW'((1 << PAGE_SHIFT) - 1);
    localparam logic [DW-1:0] ADDR_LAST = DW'(ADDR_BYTES - 1);
    localparam logic [DW-1:0] ID_LAST   = DW'(2);

    seq_state_e         state, nstate;
    req_op_e            op_q;
    logic               pending;
    logic [CNT_W-1:0]   cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DW-1:0]      dcnt;
    logic [23:0]        id_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               geo_valid_q;
    logic [7:0]         rd_data_q;
    logic               rd_valid_q;
    logic               cs_n_q;

    logic               eng_start, eng_done;
    logic [7:0]         eng_tx, eng_rx;
    logic               id_known;
    logic [SHIFT_W-1:0] id_shift;
    logic [DW-1:0]      rd_total;
    logic [ADDR_W-1:0]  page_addr, sect_addr;

    function automatic logic on_bus(seq_state_e s);
        return s inside {ST_POLL_CMD, ST_POLL_WAIT, ST_WEN, ST_OPCODE, ST_ADDR,
                         ST_RD_DATA, ST_WR_DATA, ST_ID_BYTES};
    endfunction

    function automatic logic [7:0] opcode_of(req_op_e o);
        unique case (o)
            OP_IDENT: return CMD_IDENT;
            OP_READ:  return CMD_RD;
            OP_PROG:  return CMD_PAGE_WR;
            default:  return CMD_SECT_ERASE;
        endcase
    endfunction

    nor_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .rx_byte   (eng_rx),
        .frame_done(eng_done)
    );

    nor_id_decode u_id (
        .id_bytes(id_q),
        .known   (id_known),
        .shift   (id_shift)
    );

    assign rd_total  = {cnt_q, {PAGE_SHIFT{1'b0}}};
    assign page_addr = ADDR_W'({req_index, {PAGE_SHIFT{1'b0}}});
    assign sect_addr = ADDR_W'(req_index) << shift_q;

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:
                if (req_valid)
                    nstate = (req_op_e'(req_op) == OP_IDENT) ? ST_OPCODE : ST_POLL_CMD;
            ST_POLL_CMD:
                if (eng_done) nstate = ST_POLL_WAIT;
            ST_POLL_WAIT:
                if (eng_done && !eng_rx[0]) nstate = ST_POLL_GAP;
            ST_POLL_GAP:
                nstate = (op_q == OP_READ) ? ST_OPCODE : ST_WEN;
            ST_WEN:
                if (eng_done) nstate = ST_WEN_GAP;
            ST_WEN_GAP:
                nstate = ST_OPCODE;
            ST_OPCODE:
                if (eng_done) nstate = (op_q == OP_IDENT) ? ST_ID_BYTES : ST_ADDR;
            ST_ADDR:
                if (eng_done && dcnt == ADDR_LAST) begin
                    unique case (op_q)
                        OP_READ:  nstate = (cnt_q == '0) ? ST_FINISH : ST_RD_DATA;
                        OP_PROG:  nstate = ST_WR_DATA;
                        default:  nstate = ST_FINISH;
                    endcase
                end
            ST_RD_DATA:
                if (eng_done && dcnt == rd_total - 1'b1) nstate = ST_FINISH;
            ST_WR_DATA:
                if (eng_done && dcnt == PAGE_LAST) nstate = ST_FINISH;
            ST_ID_BYTES:
                if (eng_done && dcnt == ID_LAST) nstate = ST_FINISH;
            ST_FINISH:
                nstate = ST_IDLE;
            default:
                nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cs_n_q <= 1'b1;
        end else begin
            state  <= nstate;
            cs_n_q <= !on_bus(nstate);
        end
    end

    // request capture and byte bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_IDENT;
            pending     <= 1'b0;
            cnt_q       <= '0;
            addr_q      <= '0;
            dcnt        <= '0;
            id_q        <= '0;
            shift_q     <= SHIFT_W'(SHIFT_SMALL);
            geo_valid_q <= 1'b0;
            rd_data_q   <= '0;
            rd_valid_q  <= 1'b0;
        end else begin
            if (eng_start)     pending <= 1'b1;
            else if (eng_done) pending <= 1'b0;

            if (state == ST_IDLE && req_valid) begin
                op_q   <= req_op_e'(req_op);
                cnt_q  <= req_count;
                addr_q <= (req_op_e'(req_op) == OP_ERASE) ? sect_addr : page_addr;
            end

            if (eng_done)
                dcnt <= (nstate != state) ? '0 : dcnt + 1'b1;

            if (state == ST_ADDR && eng_done)
                addr_q <= {addr_q[ADDR_W-9:0], 8'h00};

            if (state == ST_ID_BYTES && eng_done)
                id_q <= {id_q[15:0], eng_rx};

            if (state == ST_FINISH && op_q == OP_IDENT) begin
                geo_valid_q <= id_known;
                if (id_known) shift_q <= id_shift;
            end

            rd_valid_q <= (state == ST_RD_DATA) && eng_done;
            if (state == ST_RD_DATA && eng_done) rd_data_q <= eng_rx;
        end
    end

    // outputs
    always_comb begin
        eng_start = on_bus(state) && !pending && !cs_n_q;
        unique case (state)
            ST_POLL_CMD: eng_tx = CMD_STATUS;
            ST_WEN:      eng_tx = CMD_WR_EN;
            ST_OPCODE:   eng_tx = opcode_of(op_q);
            ST_ADDR:     eng_tx = addr_q[ADDR_W-1 -: 8];
            ST_WR_DATA:  eng_tx = wr_data;
            default:     eng_tx = FILLER_BYTE;
        endcase
        wr_take   = (state == ST_WR_DATA) && eng_start;
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        err       = done && (op_q == OP_IDENT) && !id_known;
        geo_valid = geo_valid_q;
        geo_shift = shift_q;
        rd_data   = rd_data_q;
        rd_valid  = rd_valid_q;
        spi_cs_n  = cs_n_q;
    end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic rd_valid,
    input logic wr_take,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    localparam int CW = $clog2(CLK_DIV + 1) + 1;

    logic          sck_q;
    logic [CW-1:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            since <= CW'(CLK_DIV);
        end else begin
            sck_q <= spi_sck;
            if (spi_sck != sck_q)          since <= '0;
            else if (since < CW'(CLK_DIV)) since <= since + 1'b1;
        end
    end

    p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_rd_in_txn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    p_take_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> !spi_cs_n);

    p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sck);

    p_mosi_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$stable(spi_mosi)) |-> $fell(spi_sck));

    p_sck_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sck != sck_q) |-> since >= CW'(CLK_DIV - 1));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    p_err_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_valid (rd_valid),
    .wr_take  (wr_take),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_index = 16'd0;
    logic [7:0]  req_count = 8'd0;
    logic        busy, done, err, geo_valid, wr_take, rd_valid;
    logic [4:0]  geo_shift;
    logic [7:0]  wr_data, rd_data;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_seq #(.CLK_DIV(DIV), .IDX_W(16), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_count(req_count), .busy(busy), .done(done),
        .err(err), .geo_valid(geo_valid), .geo_shift(geo_shift), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    int          busy_left = 0;
    logic        wel = 1'b0;
    logic [7:0]  id_m [3];
    logic [7:0]  cur_op = 8'h00;
    logic [23:0] a_m = 24'h0;
    int          bitc = 0;
    int          bytec = 0;
    logic [7:0]  sh_in = 8'h00;
    logic [7:0]  out_b = 8'h00;
    logic        miso_m = 1'b1;
    logic [7:0]  log_op [16];
    logic [23:0] log_addr [16];
    int          log_len [16];
    logic        log_wel [16];
    int          log_n = 0;
    int          pp_mism = 0;
    int          fill_mism = 0;

    assign spi_miso = miso_m;

    function automatic logic [7:0] rd_pat(logic [23:0] ad);
        return ad[7:0] ^ ad[15:8] ^ ad[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] wr_pat(int i);
        return 8'((i * 7) + 13);
    endfunction

    always @(negedge spi_cs_n) begin
        bitc = 0;
        bytec = 0;
        a_m = 24'h0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sh_in = {sh_in[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (bytec == 0) cur_op = sh_in;
                else if ((cur_op == 8'h03 || cur_op == 8'h02 || cur_op == 8'hD8) && bytec <= 3)
                    a_m = {a_m[15:0], sh_in};
                else if (cur_op == 8'h02) begin
                    if (sh_in !== wr_pat(bytec - 4)) pp_mism++;
                end else if (cur_op == 8'h05 || cur_op == 8'h9F || cur_op == 8'h03) begin
                    if (sh_in !== 8'hA5) fill_mism++;
                end
                bytec++;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (bitc == 0) begin
                out_b = 8'h00;
                if (bytec >= 1 && cur_op == 8'h05) begin
                    out_b = {6'b0, wel, busy_left > 0};
                    if (busy_left > 0) busy_left--;
                end else if (bytec >= 1 && bytec <= 3 && cur_op == 8'h9F)
                    out_b = id_m[bytec - 1];
                else if (bytec >= 4 && cur_op == 8'h03)
                    out_b = rd_pat(a_m + 24'(bytec - 4));
            end
            miso_m = out_b[7 - bitc];
        end
    end

    always @(posedge spi_cs_n) begin
        if (log_n < 16) begin
            log_op[log_n]   = cur_op;
            log_addr[log_n] = a_m;
            log_len[log_n]  = bytec;
            log_wel[log_n]  = wel;
            log_n++;
        end
        if (cur_op == 8'h06 && bytec == 1) wel = 1'b1;
        if (cur_op == 8'h02 || cur_op == 8'hD8) begin
            wel = 1'b0;
            busy_left = 0;
        end
        cur_op = 8'h00;
    end

    // ---------------- client side ----------------
    int          wr_idx = 0;
    int          takes = 0;
    logic        take_prev = 1'b0;
    int          rd_n = 0;
    int          rd_bad = 0;
    logic [23:0] rd_base = 24'h0;
    int          dones = 0;

    assign wr_data = wr_pat(wr_idx);

    always @(negedge clk) begin
        if (take_prev) wr_idx++;
        take_prev = wr_take;
        if (wr_take) takes++;
        if (rd_valid) begin
            if (rd_data !== rd_pat(rd_base + 24'(rd_n))) rd_bad++;
            rd_n++;
        end
        if (done) dones++;
    end

    task automatic chk(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        log_n = 0; pp_mism = 0; fill_mism = 0; wr_idx = 0; takes = 0;
        rd_n = 0; rd_bad = 0; dones = 0;
    endtask

    task automatic run(input logic [1:0] op, input logic [15:0] idx,
                       input logic [7:0] cnt, output logic e);
        clear_obs();
        @(negedge clk);
        req_op = op; req_index = idx; req_count = cnt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after strobe", busy, 1);
        while (!done) @(negedge clk);
        e = err;
        chk("R12 cs high at done", spi_cs_n, 1);
        @(negedge clk);
        chk("R12 done one cycle", done, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic id_case(logic [7:0] m, logic [7:0] t, logic [7:0] c);
        logic e;
        logic ok;
        id_m[0] = m; id_m[1] = t; id_m[2] = c;
        ok = (m == 8'h20) && (t == 8'h20) && (c == 8'h17 || c == 8'h18);
        run(2'd0, 16'd0, 8'd0, e);
        chk("R4 err", e, !ok);
        chk("R4 geo_valid", geo_valid, ok);
        if (ok) chk("R4 geo_shift", geo_shift, (c == 8'h17) ? 16 : 18);
        chk("R3 one transaction", log_n, 1);
        chk("R3 opcode 9F", log_op[0], 8'h9F);
        chk("R3 length", log_len[0], 4);
        chk("R11 filler", fill_mism, 0);
    endtask

    task automatic erase_case(logic [15:0] idx, int shift);
        logic e;
        busy_left = 1;
        run(2'd3, idx, 8'd0, e);
        chk("R5 poll length", log_len[0], 3);
        chk("R6 count", log_n, 3);
        chk("R6 write enable", log_op[1], 8'h06);
        chk("R6 enable length", log_len[1], 1);
        chk("R10 opcode", log_op[2], 8'hD8);
        chk("R10 address", log_addr[2], (longint'(idx) << shift) & 24'hFFFFFF);
        chk("R10 no data", log_len[2], 4);
        chk("R6 latch set", log_wel[2], 1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n reset", spi_cs_n, 1);
        chk("R1 sck reset", spi_sck, 1);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);

        // erase before identification uses shift 16
        erase_case(16'd2, 16);

        // identification sweep
        for (int c = 8'h15; c <= 8'h1A; c++) id_case(8'h20, 8'h20, 8'(c));
        id_case(8'h21, 8'h20, 8'h17);
        id_case(8'h20, 8'h10, 8'h18);
        id_case(8'h20, 8'h20, 8'h17);

        // reads with a varying busy time
        for (int p = 0; p < 4; p++) begin
            busy_left = p;
            rd_base = 24'((3 + p) << 8);
            run(2'd1, 16'(3 + p), 8'd1, e);
            chk("R5 poll count", log_n, 2);
            chk("R5 poll opcode", log_op[0], 8'h05);
            chk("R5 poll length", log_len[0], 2 + p);
            chk("R8 opcode", log_op[1], 8'h03);
            chk("R7 address", log_addr[1], rd_base);
            chk("R8 length", log_len[1], 4 + 256);
            chk("R8 bytes", rd_n, 256);
            chk("R8 data", rd_bad, 0);
            chk("R11 filler", fill_mism, 0);
        end

        busy_left = 0;
        rd_base = 24'h123400;
        run(2'd1, 16'h1234, 8'd2, e);
        chk("R7 address two pages", log_addr[1], 24'h123400);
        chk("R8 two page length", log_len[1], 4 + 512);
        chk("R8 two page bytes", rd_n, 512);
        chk("R8 two page data", rd_bad, 0);

        run(2'd1, 16'h0040, 8'd0, e);
        chk("R8 zero count length", log_len[1], 4);
        chk("R8 zero count bytes", rd_n, 0);

        // program
        for (int p = 0; p < 2; p++) begin
            busy_left = p;
            run(2'd2, (p == 0) ? 16'h0005 : 16'hFFFF, 8'd0, e);
            chk("R5 poll before program", log_len[0], 2 + p);
            chk("R6 count", log_n, 3);
            chk("R6 write enable", log_op[1], 8'h06);
            chk("R9 opcode", log_op[2], 8'h02);
            chk("R7 program address", log_addr[2], (p == 0) ? 24'h000500 : 24'hFFFF00);
            chk("R9 length", log_len[2], 4 + 256);
            chk("R9 data", pp_mism, 0);
            chk("R9 takes", takes, 256);
            chk("R6 latch set", log_wel[2], 1);
        end

        // erase with both geometries
        for (int i = 0; i < 4; i++) erase_case(16'(i * 5 + 1), 16);
        id_case(8'h20, 8'h20, 8'h18);
        for (int i = 0; i < 4; i++) erase_case(16'(i * 5 + 1), 18);

        // strobe while busy is ignored
        clear_obs();
        busy_left = 0;
        rd_base = 24'h000700;
        @(negedge clk);
        req_op = 2'd1; req_index = 16'h0007; req_count = 8'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (300) @(negedge clk);
        req_op = 2'd3; req_index = 16'h0001; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (400) @(negedge clk);
        chk("R2 ignored strobe transactions", log_n, 2);
        chk("R2 ignored strobe dones", dones, 1);
        chk("R2 read kept", log_op[1], 8'h03);
        chk("R1 idle after", spi_cs_n, 1);
        chk("R11 sck idle", spi_sck, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule